// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 1 KB data cache placed between a processor load/store port and a slower word-wide memory port. It holds 32 lines of 32 bytes, each line chosen by a fixed slice of the address. Every line has its tag, a valid flag and a dirty flag kept beside it. Loads and stores that find their line complete in the same cycle they are presented. On a miss, the processor is stalled while the controller writes back the old line (only if it was modified), brings in the new one, and then lets the held request complete as a hit.

Stores use write-back with write-allocate. A store hit changes only the cached word and marks the line dirty. A store miss first loads the whole line, then writes into it. Main memory sees traffic only when a line is filled or a dirty line is evicted, always as eight single-word beats with a request/acknowledge handshake.

The processor raises `cpu_req` with an address, a direction and, for stores, a word. It holds them until it samples `cpu_ready` high at a rising edge.

Top module: `dmc_cache`

## Requirements
- R1: Address bits 9:5 pick one of 32 lines, bits 31:10 form the 22-bit tag, bits 4:2 pick the word in the line, and bits 1:0 are ignored. Two addresses with equal index and different tags displace each other.
- R2: Reset marks every line invalid and clean. After reset, `cpu_ready` is high and `mem_req` is low while idle. The first access to any line misses, and no write-back beat is issued even if the line was dirty before the reset.
- R3: A load whose line is valid with a matching tag has `cpu_ready` high in the cycle it is presented, with the addressed word on `cpu_rdata`.
- R4: On a miss, `cpu_ready` stays low from the cycle the request is presented until the line has been filled and one retry cycle has passed. The held request then completes as a hit.
- R5: A miss whose victim is invalid or clean starts filling at once and issues no memory write.
- R6: A miss whose victim is dirty first issues 8 write beats (`mem_we`=1) to addresses {old tag, index, word 0..7 ascending, 2'b00} carrying the cached words. This happens before any fill beat.
- R7: A fill issues 8 read beats (`mem_we`=0) to {new tag, index, word 0..7 ascending, 2'b00}. The returned words are stored, and the line is then valid and clean.
- R8: A store hit writes the word into the cache and sets the line dirty, with no memory traffic. Memory receives the word only when the line is later evicted.
- R9: A store miss fills the line first, then writes the store word into it, leaving the line dirty. The other seven words keep their memory values.
- R10: A memory beat completes in the cycle `mem_ack` is high while `mem_req` is high. Until then `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady, whatever the acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes at this rising edge; low means stall |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 32 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Fill word, taken when `mem_ack` is high |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
The bench aims at index conflicts between lines with the same index and different tags. A design with a misplaced index or tag slice would hit where it must miss, or return data from the wrong block. It evicts a dirty line and then reloads it from memory. A cache that skipped the write-back, wrote the wrong words, or wrote them to the new tag's address would return stale data, and a cache that wrote back clean victims would show extra write beats. It also clears the state with reset while a line is dirty, which exposes flags that survive reset. Finally, it repeats an eviction with a slow acknowledge and checks the beat order and address stability, catching beat counters that run ahead of the handshake.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Miss-handling sequence; the order of the phases is the behaviour.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RETRY = 2'd3
    } miss_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES    = 32,
    parameter int TAG_BITS = 22,
    localparam int IDX_BITS = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic                rd_valid,
    output logic                rd_dirty,
    output logic [TAG_BITS-1:0] rd_tag,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [TAG_BITS-1:0] wr_tag,
    input  logic                wr_dirty
);

    typedef struct packed {
        logic [LINES-1:0] valid;
        logic [LINES-1:0] dirty;
    } flags_t;

    flags_t flags_d, flags_q;
    logic [TAG_BITS-1:0] tag_q [LINES];

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d.valid[wr_idx] = 1'b1;
            flags_d.dirty[wr_idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // Tags carry no reset: the valid flag qualifies them.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = flags_q.valid[rd_idx];
    assign rd_dirty = flags_q.dirty[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // An installed or updated line reads back valid.
    assert_line_valid_after_write_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> flags_q.valid[$past(wr_idx)]
    );

    // The dirty flag follows the last write to its line.
    assert_dirty_follows_write_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags_q.dirty[$past(wr_idx)] == $past(wr_dirty))
    );

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES  = 32,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_BITS  = $clog2(LINES),
    localparam int WORD_BITS = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic [IDX_BITS-1:0]  rd_idx,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [IDX_BITS-1:0]  wr_idx,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic [DATA_W-1:0]    wr_data
);

    logic [DATA_W-1:0] line_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx][wr_word] <= wr_data;
        end
    end

    assign rd_data = line_q[rd_idx][rd_word];

endmodule

// File: rtl/dmc_miss_ctrl.sv
module dmc_miss_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 32,
    parameter int WORDS  = 8,
    localparam int IDX_BITS  = $clog2(LINES),
    localparam int WORD_BITS = $clog2(WORDS),
    localparam int BYTE_BITS = $clog2(DATA_W / 8),
    localparam int OFF_BITS  = WORD_BITS + BYTE_BITS,
    localparam int TAG_BITS  = ADDR_W - IDX_BITS - OFF_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    // processor side
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic                 cpu_ready,
    // tag store
    output logic [IDX_BITS-1:0]  tag_rd_idx,
    input  logic                 tag_valid,
    input  logic                 tag_dirty,
    input  logic [TAG_BITS-1:0]  tag_rd,
    output logic                 tag_wr_en,
    output logic [IDX_BITS-1:0]  tag_wr_idx,
    output logic [TAG_BITS-1:0]  tag_wr_tag,
    output logic                 tag_wr_dirty,
    // data store
    output logic [IDX_BITS-1:0]  dat_rd_idx,
    output logic [WORD_BITS-1:0] dat_rd_word,
    input  logic [DATA_W-1:0]    dat_rd,
    output logic                 dat_wr_en,
    output logic [IDX_BITS-1:0]  dat_wr_idx,
    output logic [WORD_BITS-1:0] dat_wr_word,
    output logic [DATA_W-1:0]    dat_wr_data,
    // memory side
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ack
);

    localparam logic [WORD_BITS-1:0] LAST_BEAT = WORD_BITS'(WORDS - 1);

    typedef struct packed {
        miss_state_e          st;
        logic [WORD_BITS-1:0] beat;
        logic [IDX_BITS-1:0]  idx;
        logic [TAG_BITS-1:0]  new_tag;
        logic [TAG_BITS-1:0]  old_tag;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [IDX_BITS-1:0]  cpu_idx;
    logic [TAG_BITS-1:0]  cpu_tag;
    logic [WORD_BITS-1:0] cpu_word;
    logic                 lookup_hit;
    logic [BYTE_BITS-1:0] unused_byte_sel;

    assign cpu_idx         = cpu_addr[OFF_BITS +: IDX_BITS];
    assign cpu_tag         = cpu_addr[ADDR_W-1 -: TAG_BITS];
    assign cpu_word        = cpu_addr[BYTE_BITS +: WORD_BITS];
    assign unused_byte_sel = cpu_addr[BYTE_BITS-1:0];
    assign tag_rd_idx      = cpu_idx;
    assign lookup_hit      = tag_valid && (tag_rd == cpu_tag);

    always_comb begin
        ctrl_d       = ctrl_q;
        cpu_ready    = 1'b0;
        tag_wr_en    = 1'b0;
        tag_wr_idx   = ctrl_q.idx;
        tag_wr_tag   = ctrl_q.new_tag;
        tag_wr_dirty = 1'b0;
        dat_wr_en    = 1'b0;
        dat_wr_idx   = ctrl_q.idx;
        dat_wr_word  = ctrl_q.beat;
        dat_wr_data  = mem_rdata;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        dat_rd_idx   = ctrl_q.idx;
        dat_rd_word  = ctrl_q.beat;

        unique case (ctrl_q.st)
            ST_IDLE: begin
                dat_rd_idx  = cpu_idx;
                dat_rd_word = cpu_word;
                cpu_ready   = !cpu_req || lookup_hit;
                if (cpu_req && lookup_hit) begin
                    if (cpu_we) begin
                        dat_wr_en    = 1'b1;
                        dat_wr_idx   = cpu_idx;
                        dat_wr_word  = cpu_word;
                        dat_wr_data  = cpu_wdata;
                        tag_wr_en    = 1'b1;
                        tag_wr_idx   = cpu_idx;
                        tag_wr_tag   = cpu_tag;
                        tag_wr_dirty = 1'b1;
                    end
                end else if (cpu_req) begin
                    ctrl_d.idx     = cpu_idx;
                    ctrl_d.new_tag = cpu_tag;
                    ctrl_d.old_tag = tag_rd;
                    ctrl_d.beat    = '0;
                    ctrl_d.st      = (tag_valid && tag_dirty) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ctrl_q.old_tag, ctrl_q.idx, ctrl_q.beat, {BYTE_BITS{1'b0}}};
                mem_wdata = dat_rd;
                if (mem_ack) begin
                    ctrl_d.beat = ctrl_q.beat + 1'b1;
                    if (ctrl_q.beat == LAST_BEAT) begin
                        ctrl_d.beat = '0;
                        ctrl_d.st   = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {ctrl_q.new_tag, ctrl_q.idx, ctrl_q.beat, {BYTE_BITS{1'b0}}};
                if (mem_ack) begin
                    dat_wr_en   = 1'b1;
                    ctrl_d.beat = ctrl_q.beat + 1'b1;
                    if (ctrl_q.beat == LAST_BEAT) begin
                        ctrl_d.beat = '0;
                        tag_wr_en   = 1'b1;
                        ctrl_d.st   = ST_RETRY;
                    end
                end
            end
            ST_RETRY: begin
                ctrl_d.st = ST_IDLE;
            end
            default: begin
                ctrl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, beat: '0, idx: '0, new_tag: '0, old_tag: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // A stalled request in idle always leaves idle on the next edge.
    assert_miss_leaves_idle_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && cpu_req && !cpu_ready) |=> (ctrl_q.st != ST_IDLE)
    );

    // Outside idle the processor is held off.
    assert_busy_holds_cpu_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_q.st != ST_IDLE) |-> !cpu_ready
    );

    // A clean or empty victim goes straight to fill.
    assert_clean_victim_fills_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && cpu_req && !cpu_ready && !(tag_valid && tag_dirty))
            |=> (ctrl_q.st == ST_FILL)
    );

    // A dirty victim is written back first.
    assert_dirty_victim_writes_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && cpu_req && !cpu_ready && tag_valid && tag_dirty)
            |=> (ctrl_q.st == ST_WBACK)
    );

    // Hits, including store hits, leave memory untouched.
    assert_idle_no_memory_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE) |-> !mem_req
    );

    // A pending beat holds its request, direction and address.
    assert_beat_held_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))
    );

    // Each acknowledged beat that is not the last advances by one word.
    assert_beat_ascends_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && ctrl_q.beat != LAST_BEAT)
            |=> (ctrl_q.beat == $past(ctrl_q.beat) + 1'b1)
    );

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 32,
    parameter int WORDS  = 8,
    localparam int IDX_BITS  = $clog2(LINES),
    localparam int WORD_BITS = $clog2(WORDS),
    localparam int BYTE_BITS = $clog2(DATA_W / 8),
    localparam int TAG_BITS  = ADDR_W - IDX_BITS - WORD_BITS - BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [IDX_BITS-1:0]  tag_rd_idx;
    logic                 tag_valid;
    logic                 tag_dirty;
    logic [TAG_BITS-1:0]  tag_rd;
    logic                 tag_wr_en;
    logic [IDX_BITS-1:0]  tag_wr_idx;
    logic [TAG_BITS-1:0]  tag_wr_tag;
    logic                 tag_wr_dirty;
    logic [IDX_BITS-1:0]  dat_rd_idx;
    logic [WORD_BITS-1:0] dat_rd_word;
    logic [DATA_W-1:0]    dat_rd;
    logic                 dat_wr_en;
    logic [IDX_BITS-1:0]  dat_wr_idx;
    logic [WORD_BITS-1:0] dat_wr_word;
    logic [DATA_W-1:0]    dat_wr_data;

    dmc_miss_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LINES  (LINES),
        .WORDS  (WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ready    (cpu_ready),
        .tag_rd_idx   (tag_rd_idx),
        .tag_valid    (tag_valid),
        .tag_dirty    (tag_dirty),
        .tag_rd       (tag_rd),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_idx   (tag_wr_idx),
        .tag_wr_tag   (tag_wr_tag),
        .tag_wr_dirty (tag_wr_dirty),
        .dat_rd_idx   (dat_rd_idx),
        .dat_rd_word  (dat_rd_word),
        .dat_rd       (dat_rd),
        .dat_wr_en    (dat_wr_en),
        .dat_wr_idx   (dat_wr_idx),
        .dat_wr_word  (dat_wr_word),
        .dat_wr_data  (dat_wr_data),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack)
    );

    dmc_tag_store #(
        .LINES    (LINES),
        .TAG_BITS (TAG_BITS)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (tag_rd_idx),
        .rd_valid (tag_valid),
        .rd_dirty (tag_dirty),
        .rd_tag   (tag_rd),
        .wr_en    (tag_wr_en),
        .wr_idx   (tag_wr_idx),
        .wr_tag   (tag_wr_tag),
        .wr_dirty (tag_wr_dirty)
    );

    dmc_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (dat_rd_idx),
        .rd_word (dat_rd_word),
        .rd_data (dat_rd),
        .wr_en   (dat_wr_en),
        .wr_idx  (dat_wr_idx),
        .wr_word (dat_wr_word),
        .wr_data (dat_wr_data)
    );

    assign cpu_rdata = dat_rd;

endmodule

// File: tb/tb_dmc_cache.sv
`timescale 1ns/1ps
module tb_dmc_cache;

    localparam int MEM_WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack = 1'b0;

    dmc_cache dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    always #4 clk = ~clk;   // 125 MHz

    // ---------------- backing memory model ----------------
    logic [31:0] bmem [MEM_WORDS];
    int          ack_delay = 0;
    int          ack_cnt = 0;
    int          wr_beats = 0;
    int          log_n = 0;
    logic [32:0] log_ev [32];   // {we, addr}
    int          hs_err = 0;
    logic        prev_wait = 1'b0;
    logic [32:0] prev_beat = '0;

    assign mem_rdata = bmem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (prev_wait && (!mem_req || {mem_we, mem_addr} != prev_beat)) hs_err = hs_err + 1;
        prev_wait = mem_req && !mem_ack;
        prev_beat = {mem_we, mem_addr};
        if (mem_req && mem_ack) begin
            if (log_n < 32) log_ev[log_n] = {mem_we, mem_addr};
            log_n = log_n + 1;
            if (mem_we) begin
                bmem[mem_addr[13:2]] <= mem_wdata;
                wr_beats = wr_beats + 1;
            end
        end
        if (!rst_n) begin
            mem_ack <= 1'b0;
            ack_cnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (ack_cnt >= ack_delay) begin
                mem_ack <= 1'b1;
                ack_cnt = 0;
            end else begin
                ack_cnt = ack_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- check bookkeeping ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cpu_req = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
    endtask

    // Presents one access and holds it until accepted.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        stalls    = 0;
        rd        = '0;
        forever begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            stalls++;
            if (stalls > 2000) begin
                check(1'b0, "watchdog-access", 32'(stalls), 32'd0);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        miss;
        logic [3:0]  wb;
        logic [3:0]  rid;
    } vec_t;

    // memory initial value of word w is 32'h5A000000 + w
    localparam vec_t VECS [12] = '{
        '{1'b0, 32'h0000_0040, 32'h0,          32'h5A00_0010, 1'b1, 4'd0, 4'd7}, // R7 cold fill
        '{1'b0, 32'h0000_004C, 32'h0,          32'h5A00_0013, 1'b0, 4'd0, 4'd3}, // R3 load hit
        '{1'b1, 32'h0000_0044, 32'h1111_2222,  32'h0,         1'b0, 4'd0, 4'd8}, // R8 store hit
        '{1'b0, 32'h0000_0044, 32'h0,          32'h1111_2222, 1'b0, 4'd0, 4'd3}, // R3
        '{1'b0, 32'h0000_0440, 32'h0,          32'h5A00_0110, 1'b1, 4'd8, 4'd6}, // R6 dirty victim
        '{1'b0, 32'h0000_0044, 32'h0,          32'h1111_2222, 1'b1, 4'd0, 4'd5}, // R5 clean victim
        '{1'b1, 32'h0000_07E0, 32'hCAFE_F00D,  32'h0,         1'b1, 4'd0, 4'd9}, // R9 store miss
        '{1'b0, 32'h0000_07E4, 32'h0,          32'h5A00_01F9, 1'b0, 4'd0, 4'd9}, // R9
        '{1'b0, 32'h0000_07E0, 32'h0,          32'hCAFE_F00D, 1'b0, 4'd0, 4'd9}, // R9
        '{1'b0, 32'h0000_03E0, 32'h0,          32'h5A00_00F8, 1'b1, 4'd8, 4'd6}, // R6
        '{1'b0, 32'h0000_07E0, 32'h0,          32'hCAFE_F00D, 1'b1, 4'd0, 4'd1}, // R1 conflict
        '{1'b0, 32'h0000_2000, 32'h0,          32'h5A00_0800, 1'b1, 4'd0, 4'd1}  // R1
    };

    initial begin
        logic [31:0] rd;
        int          st;
        int          wb0;
        string       tag;

        for (int w = 0; w < MEM_WORDS; w++) bmem[w] = 32'h5A00_0000 + 32'(w);
        do_reset();

        // R2: reset state at the ports
        #1;
        check(cpu_ready === 1'b1, "R2 ready after reset", 32'(cpu_ready), 32'd1);
        check(mem_req === 1'b0, "R2 no mem_req after reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < 12; i++) begin
            tag = $sformatf("R%0d vec%0d", VECS[i].rid, i);
            wb0 = wr_beats;
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, st);
            check((st > 0) == VECS[i].miss, {tag, " miss"}, 32'(st), 32'(VECS[i].miss));
            if (VECS[i].miss)
                check(st >= 18, {tag, " R4 stall length"}, 32'(st), 32'd18);
            check((wr_beats - wb0) == int'(VECS[i].wb), {tag, " write beats"},
                  32'(wr_beats - wb0), 32'(VECS[i].wb));
            if (!VECS[i].we)
                check(rd === VECS[i].exp, {tag, " rdata"}, rd, VECS[i].exp);
            if (i == 2)   // R8: store hit left memory untouched
                check(bmem[32'h11] === 32'h5A00_0011, "R8 memory after store hit",
                      bmem[32'h11], 32'h5A00_0011);
        end

        // R2: dirty line discarded by reset
        access(1'b1, 32'h0000_07E0, 32'h0BAD_BEEF, rd, st);
        check(st == 0, "R2 setup store hit", 32'(st), 32'd0);
        do_reset();
        wb0 = wr_beats;
        access(1'b0, 32'h0000_07E4, 32'h0, rd, st);
        check(st > 0, "R2 miss after reset", 32'(st), 32'd1);
        check(wr_beats == wb0, "R2 no write-back after reset", 32'(wr_beats - wb0), 32'd0);
        check(rd === 32'h5A00_01F9, "R2 rdata after reset", rd, 32'h5A00_01F9);

        // R6/R7/R10: slow acknowledge, beat order of a dirty eviction
        ack_delay = 3;
        access(1'b1, 32'h0000_0100, 32'h600D_F00D, rd, st);
        log_n = 0;
        access(1'b0, 32'h0000_0500, 32'h0, rd, st);
        check(log_n == 16, "R6 R7 beat count", 32'(log_n), 32'd16);
        for (int k = 0; k < 8; k++) begin
            check(log_ev[k] === {1'b1, 32'h100 + 32'(4 * k)}, "R6 write-back beat order",
                  log_ev[k][31:0], 32'h100 + 32'(4 * k));
            check(log_ev[k + 8] === {1'b0, 32'h500 + 32'(4 * k)}, "R7 fill beat order",
                  log_ev[k + 8][31:0], 32'h500 + 32'(4 * k));
        end
        check(rd === 32'h5A00_0140, "R10 rdata slow ack", rd, 32'h5A00_0140);
        check(bmem[32'h40] === 32'h600D_F00D, "R9 allocated store written back",
              bmem[32'h40], 32'h600D_F00D);
        check(bmem[32'h41] === 32'h5A00_0041, "R9 neighbour word kept",
              bmem[32'h41], 32'h5A00_0041);
        access(1'b0, 32'h0000_0100, 32'h0, rd, st);
        check(rd === 32'h600D_F00D, "R10 reload after slow eviction", rd, 32'h600D_F00D);
        check(hs_err == 0, "R10 beat held until ack", 32'(hs_err), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule